// File: doc/BRIEF.md
# Trigger-Restarted Capture Timer with Compare Toggle

This block is a free-running up-counter that an external trigger can restart. When the selected edge arrives on the trigger input, the counter's current value is copied into a capture register and the counter returns to zero in the same clock step. It then counts up again on each count-enable strobe. The strobe comes from a prescaler outside the block.

A programmable compare value is checked against the count on every strobe. A hit raises a one-cycle compare interrupt and inverts a toggle output. The toggle output therefore changes a fixed number of counts after each restart, which makes the block useful for pulse-width measurement and for delayed, trigger-aligned output flips.

The counter only runs when the mode field holds the run code. Any other code stops the counter and holds it at zero.

Top module: `capclr_timer`

## Requirements
- R1: With `mode_sel` = 2'b01 (run) and no trigger event, the count rises by one on each clock where `cnt_en` is high, wraps from FFFFh to 0000h, and holds when `cnt_en` is low.
- R2: The trigger input passes through a two-flop synchronizer. A level change first sampled at clock edge n is acted on at edge n+2.
- R3: A valid trigger edge in run mode loads the pre-edge count into `cap_value` and forces the count to zero at the same clock edge. This happens whether or not `cnt_en` is high.
- R4: `edge_sel` encoding: 2'b00 no edge is valid, 2'b01 rising, 2'b10 falling, 2'b11 both.
- R5: Each capture drives `cap_irq` high for the single cycle that follows the capturing edge.
- R6: In run mode, a clock with `cnt_en` high and count equal to the compare value is a match. A match drives `cmp_irq` high for one cycle and inverts `tog_out`.
- R7: When a capture and a match fall on the same clock, the capture and clear still happen. The match is still flagged and toggles the output, judged on the pre-clear count.
- R8: While `mode_sel` is not 2'b01, the count is held at zero, and trigger edges and matches have no effect. `cap_value` keeps its last value.
- R9: `cmp_wr` loads `cmp_wdata` as the compare value from the next clock onward. The compare value resets to 0000h.
- R10: `out_init_wr` loads `out_init_val` into `tog_out`. It overrides a toggle that a match would make in the same clock.
- R11: After reset, the count, `cap_value`, both interrupts and `tog_out` are all zero.
- R12: With compare value 0001h and `cnt_en` high each clock, `tog_out` flips at the second clock after a trigger-driven clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Prescaled count strobe |
| trig_in | input | 1 | Asynchronous external trigger |
| edge_sel | input | 2 | Valid trigger edge selection |
| mode_sel | input | 2 | Mode code; 2'b01 runs the capture-clear timer |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value to write |
| out_init_wr | input | 1 | Toggle output level load strobe |
| out_init_val | input | 1 | Level to load into the toggle output |
| cnt_value | output | 16 | Current count |
| cap_value | output | 16 | Last captured count |
| cap_irq | output | 1 | Capture interrupt pulse |
| cmp_irq | output | 1 | Compare-match interrupt pulse |
| tog_out | output | 1 | Toggle output |

## Verification
Matching is tested with small compare values while the trigger toggles at random. This forces captures onto the same clock as matches. A design that let the clear suppress the match would miss a toggle, and one that compared against the cleared count would flip at the wrong time.

The synchronizer latency is pinned down to the exact edge, so an extra or missing stage shows up as a capture one cycle early or late. The bench also covers:
- stop mode, where a design that froze the count instead of zeroing it, or still captured, is caught;
- a full wrap through FFFFh, which catches a wrong counter width;
- an initial-level load written in the same clock as a match, which catches a wrong write precedence.

// File: rtl/capclr_pkg.sv
package capclr_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam logic [1:0] MODE_RUN = 2'b01;

endpackage

// File: rtl/capclr_trig_edge.sv
module capclr_trig_edge #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_in,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);
    import capclr_pkg::*;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } st_t;

    st_t              st_d, st_q;
    logic [STAGES-1:0] shifted;

    generate
        if (STAGES == 1) begin : g_one
            assign shifted = trig_in;
        end else begin : g_many
            assign shifted = {st_q.sync[STAGES-2:0], trig_in};
        end
    endgenerate

    logic lvl, rise, fall;
    assign lvl  = st_q.sync[STAGES-1];
    assign rise = lvl & ~st_q.last;
    assign fall = ~lvl & st_q.last;

    always_comb begin
        st_d      = st_q;
        st_d.sync = shifted;
        st_d.last = lvl;
        case (edge_sel_e'(edge_sel))
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/capclr_count_unit.sv
module capclr_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cnt_en,
    input  logic             edge_hit,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             match_hit,
    output logic             cap_hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] cmp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        match_hit = run & cnt_en & (st_q.cnt == st_q.cmp);
        cap_hit   = run & edge_hit;
        if (cap_hit) begin
            st_d.cap = st_q.cnt;
            st_d.cnt = '0;
        end else if (!run) begin
            st_d.cnt = '0;
        end else if (cnt_en) begin
            st_d.cnt = st_q.cnt + ONE;
        end
        if (cmp_wr) st_d.cmp = cmp_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cap = st_q.cap;

endmodule

// File: rtl/capclr_out_ctrl.sv
module capclr_out_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic match_hit,
    input  logic cap_hit,
    input  logic init_wr,
    input  logic init_val,
    output logic cmp_irq,
    output logic cap_irq,
    output logic tog
);
    typedef struct packed {
        logic cmp_irq;
        logic cap_irq;
        logic tog;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cmp_irq = match_hit;
        st_d.cap_irq = cap_hit;
        if (init_wr)        st_d.tog = init_val;
        else if (match_hit) st_d.tog = ~st_q.tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_irq = st_q.cmp_irq;
    assign cap_irq = st_q.cap_irq;
    assign tog     = st_q.tog;

endmodule

// File: rtl/capclr_timer.sv
module capclr_timer #(
    parameter int         CNT_W       = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] RUN_CODE    = capclr_pkg::MODE_RUN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             trig_in,
    input  logic [1:0]       edge_sel,
    input  logic [1:0]       mode_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             out_init_wr,
    input  logic             out_init_val,
    output logic [CNT_W-1:0] cnt_value,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_irq,
    output logic             cmp_irq,
    output logic             tog_out
);
    logic run, edge_hit, match_hit, cap_hit;

    assign run = (mode_sel == RUN_CODE);

    capclr_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .edge_sel (edge_sel),
        .edge_hit (edge_hit)
    );

    capclr_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cnt_en    (cnt_en),
        .edge_hit  (edge_hit),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .cnt       (cnt_value),
        .cap       (cap_value),
        .match_hit (match_hit),
        .cap_hit   (cap_hit)
    );

    capclr_out_ctrl u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_hit (match_hit),
        .cap_hit   (cap_hit),
        .init_wr   (out_init_wr),
        .init_val  (out_init_val),
        .cmp_irq   (cmp_irq),
        .cap_irq   (cap_irq),
        .tog       (tog_out)
    );

endmodule

// File: rtl/capclr_timer_chk.sv
module capclr_timer_chk #(
    parameter int         CNT_W    = 16,
    parameter logic [1:0] RUN_CODE = 2'b01
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [1:0]       mode_sel,
    input logic             out_init_wr,
    input logic             out_init_val,
    input logic [CNT_W-1:0] cnt_value,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_irq,
    input logic             cmp_irq,
    input logic             tog_out
);
    // R1: a strobe in run mode without a capture advances the count by one
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel == RUN_CODE) && $past(cnt_en) && !cap_irq)
        |-> cnt_value == CNT_W'($past(cnt_value) + 1'b1));

    // R3: a capture leaves the counter at zero
    a_r3_clear_on_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> cnt_value == '0);

    // R5: the captured value only changes together with a capture pulse
    a_r5_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_irq |-> $stable(cap_value));

    // R6: a match inverts the output unless a level load took precedence
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cmp_irq && !$past(out_init_wr)) |-> tog_out != $past(tog_out));

    // R8: outside run mode, nothing counts, captures or matches
    a_r8_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel != RUN_CODE))
        |-> (cnt_value == '0 && !cap_irq && !cmp_irq));

    // R10: a level load wins over everything else
    a_r10_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(out_init_wr)) |-> tog_out == $past(out_init_val));

endmodule

bind capclr_timer capclr_timer_chk #(.CNT_W(CNT_W), .RUN_CODE(RUN_CODE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_en       (cnt_en),
    .mode_sel     (mode_sel),
    .out_init_wr  (out_init_wr),
    .out_init_val (out_init_val),
    .cnt_value    (cnt_value),
    .cap_value    (cap_value),
    .cap_irq      (cap_irq),
    .cmp_irq      (cmp_irq),
    .tog_out      (tog_out)
);

// File: tb/capclr_timer_bench.sv
module capclr_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        trig_in = 1'b0;
    logic [1:0]  edge_sel = 2'b01;
    logic [1:0]  mode_sel = 2'b00;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        out_init_wr = 1'b0;
    logic        out_init_val = 1'b0;
    logic [15:0] cnt_value, cap_value;
    logic        cap_irq, cmp_irq, tog_out;

    capclr_timer u_capclr_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_in(trig_in),
        .edge_sel(edge_sel), .mode_sel(mode_sel), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .out_init_wr(out_init_wr),
        .out_init_val(out_init_val), .cnt_value(cnt_value),
        .cap_value(cap_value), .cap_irq(cap_irq), .cmp_irq(cmp_irq),
        .tog_out(tog_out)
    );

    always #10 clk = ~clk;  // 50 MHz

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt = 0, m_cap = 0, m_cmp = 0;
    bit m_capi = 0, m_cmpi = 0, m_tog = 0;
    bit hist[$] = '{0, 0, 0};  // trigger samples, newest first

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cap = 0; m_cmp = 0;
            m_capi = 0; m_cmpi = 0; m_tog = 0;
            hist = '{0, 0, 0};
        end else begin
            bit nw, od, ev, run, match;
            nw = hist[1];
            od = hist[2];
            case (edge_sel)
                2'b01: ev = nw && !od;
                2'b10: ev = !nw && od;
                2'b11: ev = nw != od;
                default: ev = 0;
            endcase
            run   = (mode_sel == 2'b01);
            match = run && cnt_en && (m_cnt == m_cmp);
            m_cmpi = match;
            m_capi = run && ev;
            if (run && ev) begin
                m_cap = m_cnt;
                m_cnt = 0;
            end else if (!run) m_cnt = 0;
            else if (cnt_en) m_cnt = (m_cnt + 1) % 65536;
            if (out_init_wr) m_tog = out_init_val;
            else if (match)  m_tog = !m_tog;
            if (cmp_wr) m_cmp = cmp_wdata;
            hist.push_front(trig_in);
            void'(hist.pop_back());
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R1 count", cnt_value, m_cnt);
            chk("R3 capture value", cap_value, m_cap);
            chk("R5 capture irq", cap_irq, m_capi);
            chk((m_capi && m_cmpi) ? "R7 match irq" : "R6 match irq", cmp_irq, m_cmpi);
            chk((m_capi && m_cmpi) ? "R7 toggle" : "R6 toggle", tog_out, m_tog);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drv();  // move to just after the next rising edge
        @(posedge clk);
        #4;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cmp(input int v);
        drv(); cmp_wr = 1; cmp_wdata = 16'(v);
        drv(); cmp_wr = 0;
    endtask

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int tog0;
        cmp_on = 1;
        wait_neg(3);
        // R11: reset state
        chk("R11 count", cnt_value, 0);
        chk("R11 capture", cap_value, 0);
        chk("R11 irqs", {cap_irq, cmp_irq, tog_out}, 0);
        drv(); rst_n = 1;

        // R8: stopped mode holds zero even with strobes
        cnt_en = 1;
        wait_neg(4);
        chk("R8 stopped count", cnt_value, 0);

        // R9: compare reset to zero -> entering run gives match at count 0
        drv(); mode_sel = 2'b01; cnt_en = 1;
        wait_neg(2);
        chk("R9 reset compare match", cmp_irq, 1);

        // R1/R3/R2: count to a known value, freeze, trigger rising edge
        set_cmp(16'h8000);
        repeat (6) drv();
        cnt_en = 0;
        drv();
        tog0 = cnt_value;
        trig_in = 1;
        wait_neg(3);
        chk("R2 no early capture", cap_irq, 0);
        wait_neg(1);
        chk("R2 capture latency", cap_irq, 1);
        chk("R3 captured frozen count", cap_value, tog0);
        chk("R3 cleared", cnt_value, 0);
        wait_neg(1);
        chk("R5 single pulse", cap_irq, 0);

        // R4: falling edge ignored under rising select, taken under falling
        drv(); trig_in = 0;
        wait_neg(5);
        chk("R4 falling ignored", cap_irq, 0);
        drv(); edge_sel = 2'b10; trig_in = 1;
        drv(); trig_in = 0;
        wait_neg(4);
        chk("R4 falling taken", cap_irq, 1);
        // R4: none selected
        drv(); edge_sel = 2'b00; trig_in = 1;
        wait_neg(5);
        chk("R4 none ignores", cap_irq, 0);
        drv(); trig_in = 0;
        repeat (4) drv();

        // R12: compare 1, strobe every clock, toggle two clocks after clear
        set_cmp(1);
        edge_sel = 2'b01; cnt_en = 1; trig_in = 1;
        wait_neg(4);
        chk("R12 capture", cap_irq, 1);
        tog0 = tog_out;
        wait_neg(1);
        chk("R12 no flip yet", tog_out, tog0);
        wait_neg(1);
        chk("R12 flip", tog_out, !tog0);
        drv(); trig_in = 0;

        // R10: level load in the same clock as a match wins
        drv(); mode_sel = 2'b00;
        drv(); mode_sel = 2'b01; set_cmp(0);
        drv(); mode_sel = 2'b00;
        drv(); mode_sel = 2'b01; cnt_en = 1; out_init_wr = 1; out_init_val = 1;
        drv(); out_init_wr = 0;
        chk("R10 load beats match", tog_out, 1);

        // R8: leaving run mode clears the count, keeps capture
        repeat (5) drv();
        tog0 = cap_value;
        mode_sel = 2'b10; trig_in = 1;
        wait_neg(6);
        chk("R8 count zero", cnt_value, 0);
        chk("R8 capture kept", cap_value, tog0);
        drv(); trig_in = 0;

        // R7/R6: random traffic with small compare values
        mode_sel = 2'b01;
        for (int i = 0; i < 3000; i++) begin
            drv();
            cnt_en       = ($urandom % 4) != 0;
            if ($urandom % 3 == 0) trig_in = !trig_in;
            if ($urandom % 64 == 0) edge_sel = 2'($urandom);
            mode_sel     = ($urandom % 40 == 0) ? 2'b11 : 2'b01;
            cmp_wr       = ($urandom % 16 == 0);
            cmp_wdata    = 16'($urandom % 6);
            out_init_wr  = ($urandom % 50 == 0);
            out_init_val = 1'($urandom);
        end

        // R1: full wrap through FFFFh
        drv();
        cmp_wr = 0; out_init_wr = 0; trig_in = 0; edge_sel = 2'b00;
        mode_sel = 2'b00;
        drv(); mode_sel = 2'b01; set_cmp(16'hFFFF);
        cnt_en = 1;
        repeat (65545) drv();
        chk("R1 wrapped", cnt_value < 16'd20 ? 1 : 0, 1);

        drv();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule